// File: doc/BRIEF.md
# Partitioned Sub-Word SIMD Adder

This block is a 64-bit adder whose carry chain can be cut at byte boundaries, so one word-wide datapath performs one 64-bit, two 32-bit, four 16-bit or eight 8-bit additions or subtractions in parallel. The word is built from eight 8-bit segment adders. The carry out of one segment reaches the next segment only when the next segment does not start a new lane for the chosen lane size. Subtraction inverts the second operand and forces a carry-in of one into the lowest segment of every lane.

A caller presents two operand words, a lane-size code and an add/subtract select together with a valid strobe. One cycle later the registered result word, a per-lane carry vector and an output valid appear. Lanes sit in consecutive, aligned positions: lane i of width w occupies bits [i*w+w-1 : i*w].

Top module: `simd_split_adder`

## Requirements
- R1: While reset is held and after its release with no valid input, out_valid, sum and lane_carry are all zero.
- R2: With lane_mode = 3 (one 64-bit lane), sum is (opa + opb) mod 2^64 and lane_carry[7] is the carry out of bit 63.
- R3: With lane_mode = 2 (two 32-bit lanes at bits 31:0 and 63:32), each half of sum is computed on its own and no carry passes from bit 31 into bit 32.
- R4: With lane_mode = 1 (four 16-bit lanes), each 16-bit field of sum depends only on the same field of the operands.
- R5: With lane_mode = 0 (eight 8-bit lanes), each byte of sum is the byte-wise sum of the operand bytes with no inter-byte carry.
- R6: With sub_en = 1, every lane of sum holds (a - b) mod 2^w for its width w, formed as a + ~b + 1 per lane.
- R7: lane_carry bit (i+1)*(w/8)-1 holds the carry out of the top bit of lane i (for subtraction 1 means no borrow); every other bit of lane_carry is zero.
- R8: out_valid is high in exactly the cycle after a cycle with in_valid high, and sum and lane_carry then show that operation's result.
- R9: In a cycle with in_valid low, sum and lane_carry keep their previous values on the next edge whatever the operands, mode and op are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| lane_mode | input | 2 | Lane size: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit |
| sub_en | input | 1 | 0 = add, 1 = subtract (opa - opb) |
| opa | input | 64 | First operand word |
| opb | input | 64 | Second operand word |
| out_valid | output | 1 | Registered result is new this cycle |
| sum | output | 64 | Registered lane-wise result |
| lane_carry | output | 8 | Per-lane carry out, at the top-byte index of each lane |

## Verification
The hardest case to reach is a carry that ripples across a lane boundary. It only shows up when a lane's top segment overflows and the segment above it would react to an injected carry. Random operands seldom make a lane overflow with long all-ones runs. The stimulus therefore mixes directed all-ones-plus-one and zero-minus-one words in every lane size and random words biased toward 0xFF bytes. For each of these the bench compares against lane sums computed with whole-lane arithmetic.

// File: rtl/simd_pkg.sv
package simd_pkg;
  localparam int SEG_W  = 8;
  localparam int NSEG   = 8;
  localparam int DATA_W = SEG_W * NSEG;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    LANE8  = 2'd0,
    LANE16 = 2'd1,
    LANE32 = 2'd2,
    LANE64 = 2'd3
  } lane_mode_e;

  // Segments per lane for a mode code.
  function automatic int segs_per_lane(input logic [MODE_W-1:0] m);
    return 1 << m;
  endfunction

  // Bit k set when segment k is the lowest segment of a lane.
  function automatic logic [NSEG-1:0] lane_start_mask(input logic [MODE_W-1:0] m);
    logic [NSEG-1:0] r;
    int nb;
    nb = segs_per_lane(m);
    r = '0;
    for (int k = 0; k < NSEG; k++) begin
      if ((k % nb) == 0) r[k] = 1'b1;
    end
    return r;
  endfunction

  // Bit k set when segment k is the highest segment of a lane.
  function automatic logic [NSEG-1:0] lane_top_mask(input logic [MODE_W-1:0] m);
    logic [NSEG-1:0] r;
    int nb;
    nb = segs_per_lane(m);
    r = '0;
    for (int k = 0; k < NSEG; k++) begin
      if ((k % nb) == nb - 1) r[k] = 1'b1;
    end
    return r;
  endfunction

  // One segment of the adder: {carry, sum} of a + (b ^ inv) + cin.
  function automatic logic [SEG_W:0] seg_add(input logic [SEG_W-1:0] a,
                                             input logic [SEG_W-1:0] b,
                                             input logic inv,
                                             input logic cin);
    return {1'b0, a} + {1'b0, b ^ {SEG_W{inv}}} + {{SEG_W{1'b0}}, cin};
  endfunction
endpackage

// File: rtl/lane_decode.sv
module lane_decode
  import simd_pkg::*;
(
  input  logic [MODE_W-1:0] lane_mode,
  output logic [NSEG-1:0]   start_mask,
  output logic [NSEG-1:0]   top_mask
);
  always_comb begin
    start_mask = lane_start_mask(lane_mode);
    top_mask   = lane_top_mask(lane_mode);
  end
endmodule

// File: rtl/seg_adder.sv
module seg_adder
  import simd_pkg::*;
(
  input  logic [SEG_W-1:0] a,
  input  logic [SEG_W-1:0] b,
  input  logic             inv,
  input  logic             cin,
  output logic [SEG_W-1:0] s,
  output logic             cout
);
  logic [SEG_W:0] t;
  always_comb begin
    t    = seg_add(a, b, inv, cin);
    s    = t[SEG_W-1:0];
    cout = t[SEG_W];
  end
endmodule

// File: rtl/split_add_core.sv
module split_add_core
  import simd_pkg::*;
(
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub_en,
  input  logic [NSEG-1:0]   start_mask,
  output logic [DATA_W-1:0] sum,
  output logic [NSEG-1:0]   cout_vec,
  output logic [NSEG-1:0]   cin_vec
);
  genvar k;
  generate
    for (k = 0; k < NSEG; k++) begin : g_seg
      if (k == 0) begin : g_low
        assign cin_vec[k] = sub_en;
      end else begin : g_up
        // carry crosses only when segment k does not open a lane
        assign cin_vec[k] = start_mask[k] ? sub_en : cout_vec[k-1];
      end
      seg_adder u_seg (
        .a    (a[k*SEG_W +: SEG_W]),
        .b    (b[k*SEG_W +: SEG_W]),
        .inv  (sub_en),
        .cin  (cin_vec[k]),
        .s    (sum[k*SEG_W +: SEG_W]),
        .cout (cout_vec[k])
      );
    end
  endgenerate
endmodule

// File: rtl/simd_split_adder.sv
module simd_split_adder
  import simd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [MODE_W-1:0] lane_mode,
  input  logic              sub_en,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic              out_valid,
  output logic [DATA_W-1:0] sum,
  output logic [NSEG-1:0]   lane_carry
);
  logic [NSEG-1:0]   start_mask;
  logic [NSEG-1:0]   top_mask;
  logic [DATA_W-1:0] core_sum;
  logic [NSEG-1:0]   core_cout;
  logic [NSEG-1:0]   core_cin;

  lane_decode u_decode (
    .lane_mode  (lane_mode),
    .start_mask (start_mask),
    .top_mask   (top_mask)
  );

  split_add_core u_core (
    .a          (opa),
    .b          (opb),
    .sub_en     (sub_en),
    .start_mask (start_mask),
    .sum        (core_sum),
    .cout_vec   (core_cout),
    .cin_vec    (core_cin)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      sum        <= '0;
      lane_carry <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        sum        <= core_sum;
        lane_carry <= core_cout & top_mask;
      end
    end
  end

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R8
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(sum) && $stable(lane_carry)));
  // R7
  unused_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ((lane_carry & ~$past(top_mask)) == '0));
  // R6
  cin_inject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ((core_cin & start_mask) == (sub_en ? start_mask : '0)));
  // R2
  wide_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && lane_mode == LANE64) |=> ($countones(lane_carry) <= 1 && lane_carry[NSEG-2:0] == '0));
endmodule

// File: tb/simd_split_adder_bench.sv
`timescale 1ns/1ps
module simd_split_adder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  lane_mode = 2'd0;
  logic        sub_en = 1'b0;
  logic [63:0] opa = '0;
  logic [63:0] opb = '0;
  logic        out_valid;
  logic [63:0] sum;
  logic [7:0]  lane_carry;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  simd_split_adder u_simd_split_adder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .lane_mode(lane_mode),
    .sub_en(sub_en), .opa(opa), .opb(opb), .out_valid(out_valid),
    .sum(sum), .lane_carry(lane_carry)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Whole-lane arithmetic reference.
  task automatic ref_op(input logic [63:0] a, input logic [63:0] b, input logic [1:0] m,
                        input logic s, output logic [63:0] r, output logic [7:0] c);
    int w;
    int n;
    logic [63:0] lm;
    logic [64:0] ea, eb, t;
    w = 8 << m;
    n = 64 / w;
    lm = (w == 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
    r = '0;
    c = '0;
    for (int i = 0; i < n; i++) begin
      ea = {1'b0, (a >> (i*w)) & lm};
      eb = {1'b0, ((s ? ~b : b) >> (i*w)) & lm};
      t  = ea + eb + {64'd0, s};
      r  = r | ((t[63:0] & lm) << (i*w));
      c[(i+1)*(w/8)-1] = t[w];
    end
  endtask

  function automatic string mode_tag(input logic [1:0] m, input logic s);
    string t;
    case (m)
      2'd3: t = "R2";
      2'd2: t = "R3";
      2'd1: t = "R4";
      default: t = "R5";
    endcase
    return s ? {t, "/R6"} : t;
  endfunction

  task automatic do_op(input logic [63:0] a, input logic [63:0] b, input logic [1:0] m, input logic s);
    logic [63:0] er;
    logic [7:0]  ec;
    ref_op(a, b, m, s, er, ec);
    opa = a; opb = b; lane_mode = m; sub_en = s; in_valid = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b1, "R8 out_valid after op", {63'd0, out_valid}, 64'd1);
    chk(sum === er, mode_tag(m, s), sum, er);
    chk(lane_carry === ec, "R7 lane_carry", {56'd0, lane_carry}, {56'd0, ec});
    // idle cycle with junk inputs: nothing may change
    in_valid = 1'b0;
    opa = {$urandom, $urandom}; opb = {$urandom, $urandom};
    lane_mode = 2'($urandom); sub_en = 1'($urandom);
    @(negedge clk);
    chk(out_valid === 1'b0, "R8 out_valid idle", {63'd0, out_valid}, 64'd0);
    chk(sum === er && lane_carry === ec, "R9 hold", sum, er);
  endtask

  function automatic logic [63:0] biased_word();
    logic [63:0] v;
    v = {$urandom, $urandom};
    for (int k = 0; k < 8; k++) begin
      if ($urandom_range(0, 2) == 0) v[k*8 +: 8] = 8'hFF;
    end
    return v;
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2015));
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0 && sum === 64'd0 && lane_carry === 8'd0, "R1 in reset", sum, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b0 && sum === 64'd0 && lane_carry === 8'd0, "R1 after reset", sum, 64'd0);

    // directed corners: ripple at every boundary, borrow in every lane
    for (int m = 0; m < 4; m++) begin
      do_op({64{1'b1}}, 64'd1, 2'(m), 1'b0);
      do_op(64'd0, 64'd1, 2'(m), 1'b1);
      do_op(64'h0101010101010101, 64'd0, 2'(m), 1'b1);
      do_op({64{1'b1}}, {64{1'b1}}, 2'(m), 1'b0);
      do_op(64'h80FF7FFF_FFFF00FF, 64'h80017F01_00010001, 2'(m), 1'b0);
      do_op(64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 2'(m), 1'b1);
    end

    // random mix, biased toward carry-rich bytes
    for (int i = 0; i < 400; i++) begin
      if (i % 2 == 0) do_op(biased_word(), biased_word(), 2'($urandom), 1'($urandom));
      else            do_op({$urandom, $urandom}, {$urandom, $urandom}, 2'($urandom), 1'($urandom));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule